// File: doc/BRIEF.md
# Double-Buffered Serial Word Transmitter

This block turns 16-bit words supplied by a host into a continuous serial bit stream for a downstream modulator. The host writes into a holding register. A separate shift register sends its word one bit per baud period, most significant bit first. The baud period is set by a programmable clock divisor. When the last bit of a word has been sent, the shifter takes the holding word straight away, so there is no gap between words, and it raises an interrupt asking for the next word.

The holding register is not cleared when its word is taken. If the host does not supply a new word in time, the same word is sent again. The interrupt marks a load, not the end of a word, so it cannot tell the host when the line is quiet. A separate busy output does that. After the host drops the enable, busy stays high until the final bit period of the word in flight has finished.

Top module: `ser_word_tx`

## Requirements
- R1: After synchronous reset, `ser_out`, `busy`, `irq_pulse` and `irq_flag` are 0. With `tx_en` high but no word written since reset, none of them rises.
- R2: Transmission begins only when a word has been written since reset and `tx_en` is high. The shifter loads on the first clock edge at which both hold, and `busy` is 1 from that edge on. With `tx_en` low a written word is never sent.
- R3: Each word leaves on `ser_out` most significant bit first. Every bit is held for exactly `baud_div`+1 clock cycles (`baud_div` = 0 gives one bit per clock).
- R4: While `tx_en` stays high, the most significant bit of the next word follows the 16th bit period of the current word with no idle cycle in between.
- R5: A write to the holding register during a word does not change the bits of the word in flight. The written value is the next word sent.
- R6: If no write arrives before a word boundary, the holding word is loaded and sent again unchanged.
- R7: At every shifter load, `irq_pulse` is high for exactly one cycle and `irq_flag` is set. A write clears `irq_flag`. If a write and a load fall on the same edge, the flag ends up set.
- R8: Dropping `tx_en` takes effect only at a word boundary. The current word completes, and `busy` falls on the edge that ends its 16th bit period. While `busy` is 0, `ser_out` is 0 and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable, sampled at word boundaries while sending |
| baud_div | input | 16 | Bit period minus one, in clock cycles |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 16 | Word written into the holding register |
| ser_out | output | 1 | Serial bit to the modulator, 0 when idle |
| busy | output | 1 | High from the first load until the final bit period ends |
| irq_pulse | output | 1 | One-cycle request for a new word, at each load |
| irq_flag | output | 1 | Sticky request, cleared by a host write |

## Verification
Most internal faults show up on `ser_out` within one word. A bit counter that is off by one moves the next word's most significant bit by a whole bit period. A divisor counter that is wrong stretches or shortens the first bit, and the check at the second bit period catches it. A holding register that is cleared or overwritten on load shows up on the word after the boundary, either as zeros or as the wrong resent value. An enable that is sampled mid-word shows up as `busy` falling before the sixteenth bit period has ended. Interrupt faults are visible on the cycle right after a load edge, or on the cycle right after a host write.

// File: rtl/ser_word_tx_pkg.sv
package ser_word_tx_pkg;

    localparam int unsigned WORD_W_DEF = 16;
    localparam int unsigned DIV_W_DEF  = 16;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // per-cycle control decisions made by the sequencer
    typedef struct packed {
        logic start;   // first load from idle
        logic reload;  // back-to-back load at a word boundary
        logic shift;   // advance to next bit
        logic stop;    // word boundary with enable low
    } tx_ctl_t;

    function automatic tx_state_e next_state(input tx_state_e cur, input tx_ctl_t c);
        tx_state_e n;
        n = cur;
        if (c.start) n = TX_SEND;
        else if (c.stop) n = TX_IDLE;
        return n;
    endfunction

endpackage

// File: rtl/swt_baud_gen.sv
module swt_baud_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt >= div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt >= div);
endmodule

// File: rtl/swt_hold_reg.sv
module swt_hold_reg #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            valid <= 1'b0;
        end else if (wr_en) begin
            word  <= wr_data;
            valid <= 1'b1;
        end
    end
endmodule

// File: rtl/swt_shifter.sv
module swt_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] load_word,
    output logic              msb,
    output logic              last_bit
);
    localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            bit_idx <= '0;
        end else if (load) begin
            sreg    <= load_word;
            bit_idx <= '0;
        end else if (shift) begin
            sreg    <= {sreg[WORD_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end
    end

    assign msb      = sreg[WORD_W-1];
    assign last_bit = (bit_idx == LAST);
endmodule

// File: rtl/swt_req_flag.sv
module swt_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic wr_en,
    output logic irq_pulse,
    output logic irq_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            irq_pulse <= load;
            if (load)       irq_flag <= 1'b1;
            else if (wr_en) irq_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/ser_word_tx.sv
module ser_word_tx
    import ser_word_tx_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned DIV_W  = DIV_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              ser_out,
    output logic              busy,
    output logic              irq_pulse,
    output logic              irq_flag
);
    tx_state_e         state;
    tx_ctl_t           ctl;
    logic              baud_tick;
    logic              hold_valid;
    logic [WORD_W-1:0] hold_word;
    logic              sh_msb;
    logic              sh_last;
    logic              sending;

    assign sending = (state == TX_SEND);

    always_comb begin
        ctl        = '0;
        ctl.start  = !sending && tx_en && hold_valid;
        ctl.reload = sending && baud_tick && sh_last && tx_en;
        ctl.stop   = sending && baud_tick && sh_last && !tx_en;
        ctl.shift  = sending && baud_tick && !sh_last;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TX_IDLE;
        else     state <= next_state(state, ctl);
    end

    swt_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (sending),
        .div  (baud_div),
        .tick (baud_tick)
    );

    swt_hold_reg #(.WORD_W(WORD_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .word    (hold_word),
        .valid   (hold_valid)
    );

    swt_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.start || ctl.reload),
        .shift     (ctl.shift),
        .load_word (hold_word),
        .msb       (sh_msb),
        .last_bit  (sh_last)
    );

    swt_req_flag u_req (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.start || ctl.reload),
        .wr_en     (wr_en),
        .irq_pulse (irq_pulse),
        .irq_flag  (irq_flag)
    );

    assign ser_out = sending && sh_msb;
    assign busy    = sending;
endmodule

// File: rtl/swt_checker.sv
module swt_checker (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic wr_en,
    input logic ser_out,
    input logic busy,
    input logic irq_pulse,
    input logic irq_flag,
    input logic baud_tick
);
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ser_out && !irq_pulse));

    assert_stop_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!$past(tx_en) && $past(baud_tick)));

    assert_start_gated_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(tx_en) && irq_pulse));

    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(baud_tick)) |-> $stable(ser_out));

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

    assert_flag_on_load_R7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> irq_flag);

    assert_flag_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !irq_pulse) |-> !irq_flag);
endmodule

bind ser_word_tx swt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .wr_en     (wr_en),
    .ser_out   (ser_out),
    .busy      (busy),
    .irq_pulse (irq_pulse),
    .irq_flag  (irq_flag),
    .baud_tick (baud_tick)
);

// File: tb/sim_ser_word_tx.sv
module sim_ser_word_tx;
    logic        clk = 1'b0;
    logic        rst;
    logic        tx_en;
    logic [15:0] baud_div;
    logic        wr_en;
    logic [15:0] wr_data;
    logic        ser_out;
    logic        busy;
    logic        irq_pulse;
    logic        irq_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ser_word_tx u0 (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .baud_div  (baud_div),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ser_out   (ser_out),
        .busy      (busy),
        .irq_pulse (irq_pulse),
        .irq_flag  (irq_flag)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic [15:0] d);
        @(negedge clk);
        rst = 1'b1; tx_en = 1'b0; wr_en = 1'b0; wr_data = '0; baud_div = d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [15:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called at the negedge right after a load edge; checks one full word.
    task automatic run_word(input logic [15:0] exp, input int d, input int wbit,
                            input logic [15:0] wdata, input int dropbit, input string tag);
        for (int k = 0; k < 16; k++) begin
            chk({31'd0, ser_out}, {31'd0, exp[15-k]}, {tag, " R3 bit"});
            chk({31'd0, busy}, 32'd1, {tag, " R8 busy in word"});
            if (k == 0) chk({31'd0, irq_pulse}, 32'd1, {tag, " R7 pulse at load"});
            if (k == wbit) begin wr_en = 1'b1; wr_data = wdata; end
            if (k == dropbit) tx_en = 1'b0;
            for (int c = 0; c <= d; c++) begin
                @(negedge clk);
                if (c == 0) begin
                    if (k == wbit) chk({31'd0, irq_flag}, 32'd0, {tag, " R7 flag cleared by write"});
                    wr_en = 1'b0;
                    if (k != 15) chk({31'd0, irq_pulse}, 32'd0, {tag, " R7 pulse one cycle"});
                end
            end
        end
    endtask

    task automatic t_reset;
        do_reset(16'd2);
        chk({28'd0, ser_out, busy, irq_pulse, irq_flag}, 32'd0, "R1 reset outputs");
        tx_en = 1'b1;
        repeat (20) @(negedge clk);
        chk({28'd0, ser_out, busy, irq_pulse, irq_flag}, 32'd0, "R1 no word written");
    endtask

    task automatic t_main_flow;
        do_reset(16'd2);
        host_write(16'hA5C3);
        repeat (10) @(negedge clk);
        chk({30'd0, busy, irq_pulse}, 32'd0, "R2 enable low holds idle");
        tx_en = 1'b1;
        @(negedge clk);
        chk({31'd0, busy}, 32'd1, "R2 start on enable");
        chk({31'd0, irq_flag}, 32'd1, "R7 flag set at first load");
        run_word(16'hA5C3, 2, -1, 16'h0, -1, "w1");
        chk({31'd0, irq_flag}, 32'd1, "R6 flag still set on resend");
        // R6 stale resend, R5 write mid-word
        run_word(16'hA5C3, 2, 5, 16'h1234, -1, "w2 R6");
        // R4/R5 new word follows directly; R8 drop enable mid-word
        run_word(16'h1234, 2, -1, 16'h0, 8, "w3 R5");
        chk({30'd0, busy, ser_out}, 32'd0, "R8 busy falls after final bit");
        chk({31'd0, irq_pulse}, 32'd0, "R8 no load at stop");
        repeat (10) @(negedge clk);
        chk({30'd0, busy, ser_out}, 32'd0, "R8 stays idle");
    endtask

    task automatic t_fast_div;
        do_reset(16'd0);
        tx_en = 1'b1;
        host_write(16'h8001);
        chk({31'd0, busy}, 32'd0, "R2 load waits one edge after write");
        @(negedge clk);
        chk({31'd0, busy}, 32'd1, "R2 started");
        run_word(16'h8001, 0, -1, 16'h0, -1, "d0 w1");
        run_word(16'h8001, 0, -1, 16'h0, 0, "d0 w2 R6");
        chk({31'd0, busy}, 32'd0, "R8 stop with div 0");
    endtask

    task automatic t_slow_div;
        do_reset(16'd5);
        host_write(16'hFFFF);
        tx_en = 1'b1;
        @(negedge clk);
        chk({31'd0, busy}, 32'd1, "R2 start slow");
        run_word(16'hFFFF, 5, 15, 16'h0000, -1, "d5 w1 R4");
        run_word(16'h0000, 5, -1, 16'h0, 15, "d5 w2 R5");
        chk({30'd0, busy, ser_out}, 32'd0, "R8 stop at last bit drop");
    endtask

    initial begin
        rst = 1'b1; tx_en = 1'b0; wr_en = 1'b0; wr_data = '0; baud_div = '0;
        t_reset();
        t_main_flow();
        t_fast_div();
        t_slow_div();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule